// File: doc/BRIEF.md
# Per-Core Slowdown Estimator

This block estimates, for every core of a multi-core chip, how much slower that core runs because it shares the last-level cache and main memory with the other cores. Time is divided into quanta, and each quantum into one equal epoch per core. During its epoch a core holds top priority at the memory scheduler, so the accesses it completes there approximate its access rate when running alone. The block counts shared-cache accesses, contention misses, miss completions and their latencies per core. Contention misses are misses in the shared cache that would have hit in a private shadow tag lookup.

At the end of each quantum the block takes the contention cycles out of the core's priority epoch. The contention cycles are the contention misses multiplied by the average miss service time seen during that epoch. The block then divides the corrected alone access rate by the access rate over the whole quantum. A single sequential divider works through the cores in index order and updates one unsigned 8.8 fixed-point slowdown per core. It pulses a completion flag after the last core has been updated. A resource manager reads the slowdowns to steer cache and bandwidth allocation.

Top module: `sdm_slowdown_est`

## Requirements
- R1: `prio_o` always has exactly one bit set. After reset it selects core 0. The selected core advances by one index every EPOCH_LEN cycles and wraps from the last core back to core 0.
- R2: A quantum is NUM_CORES×EPOCH_LEN cycles, starting at the first clock edge after reset is released. Every event counter starts each quantum at zero, so one quantum's events never affect a later quantum's result.
- R3: Two access counts are kept per core. The shared count A counts every cycle with the core's `acc_i` bit high. The priority count H counts only those cycles in which the core also holds `prio_o`.
- R4: Three further counts are kept per core, only while the core holds `prio_o`. C counts cycles with both `miss_i` and `aux_hit_i` high for that core. M counts cycles with `fill_i` high. L sums the `fill_lat_i` field of the core, which is bits [8i+7:8i].
- R5: For every other case the slowdown is floor(H·Q·M·256 / (A·(E·M − C·L))), with Q the quantum length and E the epoch length. This is the alone rate H/(E − C·L/M) divided by the shared rate A/Q, in 8.8 format.
- R6: When M is zero the contention cycles are taken as zero. The slowdown is then floor(H·Q·256 / (A·E)).
- R7: The slowdown is exactly 1.0 (256) in two cases: A is zero, or E·M ≤ C·L, meaning the corrected priority epoch is empty.
- R8: Every reported slowdown is at least 256, which is 1.0. It is at most 65535, where larger quotients saturate.
- R9: Both outputs hold fixed values while reset is asserted: `slowdown_o` reads 256 for every core and `upd_done_o` reads 0. After each quantum all cores are updated and `upd_done_o` pulses for one cycle. The pulse comes no later than NUM_CORES×(NUM_W+5)+4 cycles after the quantum's last cycle, where NUM_W = 2·CNT_W + clog2(Q+1) + 8. Values hold between updates.
- R10: Every counter saturates at its all-ones value instead of wrapping. This includes the latency sum, which is LAT_W bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | NUM_CORES | Per-core shared-cache access pulse |
| miss_i | input | NUM_CORES | Per-core shared-cache miss pulse |
| aux_hit_i | input | NUM_CORES | Per-core shadow tag hit, qualifies `miss_i` |
| fill_i | input | NUM_CORES | Per-core miss completion pulse |
| fill_lat_i | input | NUM_CORES×LATI_W | Service latency of each completion, core i in slice i |
| prio_o | output | NUM_CORES | One-hot highest memory priority select |
| slowdown_o | output | NUM_CORES×SD_W | Per-core 8.8 slowdown, core i in slice i |
| upd_done_o | output | 1 | One-cycle pulse when all slowdowns are refreshed |

## Verification
A counter that is charged in the wrong epoch, or that survives into the next quantum, moves that core's slowdown away from the closed-form value. This shows at the next `upd_done_o` pulse, which comes at most a few hundred cycles after the quantum ends. A fault in the epoch sequencer shows on `prio_o` within one epoch. A divider or sequencer fault shows as a wrong value, a core left at its old value, or a missing or late completion pulse. The stimulus patterns are chosen so that each one drives a different formula branch: no fills, an empty corrected epoch, a ratio below one, a quotient that saturates, and a saturated latency sum.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int FRAC_W = 8;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT, SQ_STEP} seq_e;
endpackage

// File: rtl/sdm_sched.sv
// Epoch sequencer: rotates the top memory priority one core per epoch.
module sdm_sched #(
  parameter int NUM_CORES = 4,
  parameter int EPOCH_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [NUM_CORES-1:0] prio_o,
  output logic                 qend_o
);
  localparam int EW = $clog2(EPOCH_LEN);
  localparam int IW = $clog2(NUM_CORES);

  logic [EW-1:0] ep_cnt;
  logic [IW-1:0] owner;
  logic          ep_last;

  assign ep_last = (ep_cnt == EW'(EPOCH_LEN - 1));
  assign qend_o  = ep_last && (owner == IW'(NUM_CORES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_cnt <= '0;
      owner  <= '0;
      prio_o <= NUM_CORES'(1);
    end else if (ep_last) begin
      ep_cnt <= '0;
      owner  <= qend_o ? '0 : owner + IW'(1);
      prio_o <= {prio_o[NUM_CORES-2:0], prio_o[NUM_CORES-1]};
    end else begin
      ep_cnt <= ep_cnt + EW'(1);
    end
  end

  AST_PRIO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(prio_o) == 1); // R1
  AST_PRIO_OWNER: assert property (@(posedge clk) disable iff (rst)
    prio_o[owner]); // R1
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ep_last |=> $stable(prio_o)); // R1
endmodule

// File: rtl/sdm_core_ctr.sv
// Per-core event counters with an end-of-quantum snapshot.
module sdm_core_ctr #(
  parameter int CNT_W  = 12,
  parameter int LAT_W  = 20,
  parameter int LATI_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qend_i,
  input  logic              own_i,
  input  logic              acc_i,
  input  logic              miss_i,
  input  logic              aux_hit_i,
  input  logic              fill_i,
  input  logic [LATI_W-1:0] fill_lat_i,
  output logic [CNT_W-1:0]  snap_all_o,
  output logic [CNT_W-1:0]  snap_hp_o,
  output logic [CNT_W-1:0]  snap_cm_o,
  output logic [CNT_W-1:0]  snap_mc_o,
  output logic [LAT_W-1:0]  snap_ls_o
);
  localparam int SW = LAT_W + 1;

  logic [CNT_W-1:0] live_all, live_hp, live_cm, live_mc;
  logic [CNT_W-1:0] nxt_all, nxt_hp, nxt_cm, nxt_mc;
  logic [LAT_W-1:0] live_ls, nxt_ls;
  logic [SW-1:0]    ls_sum;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic en);
    return (en && (v != '1)) ? v + CNT_W'(1) : v;
  endfunction

  always_comb begin
    nxt_all = bump(live_all, acc_i);
    nxt_hp  = bump(live_hp,  own_i && acc_i);
    nxt_cm  = bump(live_cm,  own_i && miss_i && aux_hit_i);
    nxt_mc  = bump(live_mc,  own_i && fill_i);
    ls_sum  = {1'b0, live_ls} + SW'(fill_lat_i);
    if (own_i && fill_i) nxt_ls = ls_sum[LAT_W] ? '1 : ls_sum[LAT_W-1:0];
    else                 nxt_ls = live_ls;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {live_all, live_hp, live_cm, live_mc, live_ls} <= '0;
      {snap_all_o, snap_hp_o, snap_cm_o, snap_mc_o, snap_ls_o} <= '0;
    end else if (qend_i) begin
      {live_all, live_hp, live_cm, live_mc, live_ls} <= '0;
      snap_all_o <= nxt_all;
      snap_hp_o  <= nxt_hp;
      snap_cm_o  <= nxt_cm;
      snap_mc_o  <= nxt_mc;
      snap_ls_o  <= nxt_ls;
    end else begin
      live_all <= nxt_all;
      live_hp  <= nxt_hp;
      live_cm  <= nxt_cm;
      live_mc  <= nxt_mc;
      live_ls  <= nxt_ls;
    end
  end

  AST_NO_WRAP_ALL: assert property (@(posedge clk) disable iff (rst)
    (live_all == '1) && !qend_i |=> live_all == '1); // R10
  AST_NO_WRAP_LAT: assert property (@(posedge clk) disable iff (rst)
    (live_ls == '1) && !qend_i |=> live_ls == '1); // R10
  AST_QUANTUM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    qend_i |=> (live_all == '0) && (live_hp == '0) && (live_ls == '0)); // R2
  AST_HP_LE_ALL: assert property (@(posedge clk) disable iff (rst)
    snap_hp_o <= snap_all_o); // R3
endmodule

// File: rtl/sdm_div.sv
// Restoring divider, one quotient bit per cycle.
module sdm_div #(
  parameter int NUM_W = 43,
  parameter int DEN_W = 53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CW = $clog2(NUM_W);

  logic [DEN_W-1:0] den_q, rem;
  logic [DEN_W:0]   trial;
  logic [CW-1:0]    cnt;
  logic             busy;

  assign trial = {rem, quot_o[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done_o <= 1'b0; cnt <= '0;
      rem <= '0; den_q <= '0; quot_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy <= 1'b1; cnt <= '0; rem <= '0;
        den_q <= den_i; quot_o <= num_i;
      end else if (busy) begin
        if (trial >= {1'b0, den_q}) begin
          rem    <= DEN_W'(trial - {1'b0, den_q});
          quot_o <= {quot_o[NUM_W-2:0], 1'b1};
        end else begin
          rem    <= trial[DEN_W-1:0];
          quot_o <= {quot_o[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt + CW'(1);
        if (cnt == CW'(NUM_W - 1)) begin
          busy <= 1'b0; done_o <= 1'b1;
        end
      end
    end
  end

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> rem < den_q); // R5
  AST_DIV_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
endmodule

// File: rtl/sdm_slowdown_est.sv
module sdm_slowdown_est
  import sdm_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int EPOCH_LEN = 256,
  parameter int CNT_W     = 12,
  parameter int LAT_W     = 20,
  parameter int LATI_W    = 8,
  parameter int SD_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        acc_i,
  input  logic [NUM_CORES-1:0]        miss_i,
  input  logic [NUM_CORES-1:0]        aux_hit_i,
  input  logic [NUM_CORES-1:0]        fill_i,
  input  logic [NUM_CORES*LATI_W-1:0] fill_lat_i,
  output logic [NUM_CORES-1:0]        prio_o,
  output logic [NUM_CORES*SD_W-1:0]   slowdown_o,
  output logic                        upd_done_o
);
  localparam int QUANT  = NUM_CORES * EPOCH_LEN;
  localparam int QW     = $clog2(QUANT + 1);
  localparam int EW     = $clog2(EPOCH_LEN + 1);
  localparam int IW     = $clog2(NUM_CORES);
  localparam int PROD_W = CNT_W + LAT_W + EW;
  localparam int DEN_W  = CNT_W + PROD_W;
  localparam int NUM_W  = 2 * CNT_W + QW + FRAC_W;
  localparam logic [SD_W-1:0] ONE_FP = SD_W'(1 << FRAC_W);
  localparam logic [SD_W-1:0] SD_MAX = {SD_W{1'b1}};

  logic                 qend;
  logic [CNT_W-1:0]     s_all [NUM_CORES];
  logic [CNT_W-1:0]     s_hp  [NUM_CORES];
  logic [CNT_W-1:0]     s_cm  [NUM_CORES];
  logic [CNT_W-1:0]     s_mc  [NUM_CORES];
  logic [LAT_W-1:0]     s_ls  [NUM_CORES];
  logic [SD_W-1:0]      slow_q [NUM_CORES];

  seq_e                 st;
  logic [IW-1:0]        idx;
  logic                 div_start, div_done, trivial;
  logic [CNT_W-1:0]     mp;
  logic [PROD_W-1:0]    em, cl, corr;
  logic [NUM_W-1:0]     num, quot;
  logic [DEN_W-1:0]     den;
  logic [SD_W-1:0]      res;

  sdm_sched #(.NUM_CORES(NUM_CORES), .EPOCH_LEN(EPOCH_LEN)) u_sched (
    .clk(clk), .rst(rst), .prio_o(prio_o), .qend_o(qend));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    sdm_core_ctr #(.CNT_W(CNT_W), .LAT_W(LAT_W), .LATI_W(LATI_W)) u_ctr (
      .clk(clk), .rst(rst), .qend_i(qend), .own_i(prio_o[g]),
      .acc_i(acc_i[g]), .miss_i(miss_i[g]), .aux_hit_i(aux_hit_i[g]),
      .fill_i(fill_i[g]), .fill_lat_i(fill_lat_i[g*LATI_W +: LATI_W]),
      .snap_all_o(s_all[g]), .snap_hp_o(s_hp[g]), .snap_cm_o(s_cm[g]),
      .snap_mc_o(s_mc[g]), .snap_ls_o(s_ls[g]));
    assign slowdown_o[g*SD_W +: SD_W] = slow_q[g];

    AST_RESULT_FLOOR: assert property (@(posedge clk) disable iff (rst)
      slow_q[g] >= ONE_FP); // R8
  end

  // Operands for the core currently selected by the sequencer.
  always_comb begin
    mp      = (s_mc[idx] == '0) ? CNT_W'(1) : s_mc[idx];
    cl      = (s_mc[idx] == '0) ? '0 : PROD_W'(s_cm[idx]) * PROD_W'(s_ls[idx]);
    em      = PROD_W'(EPOCH_LEN) * PROD_W'(mp);
    trivial = (s_all[idx] == '0) || (em <= cl);
    corr    = em - cl;
    num     = (NUM_W'(s_hp[idx]) * NUM_W'(QUANT) * NUM_W'(mp)) << FRAC_W;
    den     = DEN_W'(s_all[idx]) * DEN_W'(corr);
    if (quot < NUM_W'(ONE_FP))      res = ONE_FP;
    else if (quot > NUM_W'(SD_MAX)) res = SD_MAX;
    else                            res = quot[SD_W-1:0];
  end

  sdm_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .start_i(div_start), .num_i(num), .den_i(den),
    .done_o(div_done), .quot_o(quot));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; idx <= '0; div_start <= 1'b0; upd_done_o <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++) slow_q[i] <= ONE_FP;
    end else begin
      div_start  <= 1'b0;
      upd_done_o <= 1'b0;
      case (st)
        SQ_IDLE: if (qend) begin idx <= '0; st <= SQ_LOAD; end
        SQ_LOAD: if (trivial) begin
                   slow_q[idx] <= ONE_FP; st <= SQ_STEP;
                 end else begin
                   div_start <= 1'b1; st <= SQ_WAIT;
                 end
        SQ_WAIT: if (div_done) begin slow_q[idx] <= res; st <= SQ_STEP; end
        default: if (idx == IW'(NUM_CORES - 1)) begin
                   upd_done_o <= 1'b1; st <= SQ_IDLE;
                 end else begin
                   idx <= idx + IW'(1); st <= SQ_LOAD;
                 end
      endcase
    end
  end

  AST_SEQ_IN_TIME: assert property (@(posedge clk) disable iff (rst)
    qend |-> st == SQ_IDLE); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |=> !upd_done_o); // R9
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    div_start |-> den != '0); // R7
endmodule

// File: tb/tb_sdm_slowdown_est.sv
`timescale 1ns/1ps
module tb_sdm_slowdown_est;
  localparam int N = 4, E = 256, CNT_W = 12, LAT_W = 10, LATI_W = 8, SD_W = 16;
  localparam int Q = N * E;
  localparam int NUM_W = 2 * CNT_W + $clog2(Q + 1) + 8;
  localparam int LIMIT = N * (NUM_W + 5) + 4;
  localparam longint LMAX = (64'd1 << LAT_W) - 1;
  localparam int NQ = 7;

  logic clk = 0, rst = 1;
  logic [N-1:0] acc_i = '0, miss_i = '0, aux_hit_i = '0, fill_i = '0;
  logic [N*LATI_W-1:0] fill_lat_i = '0;
  logic [N-1:0] prio_o;
  logic [N*SD_W-1:0] slowdown_o;
  logic upd_done_o;

  sdm_slowdown_est #(.NUM_CORES(N), .EPOCH_LEN(E), .CNT_W(CNT_W), .LAT_W(LAT_W),
    .LATI_W(LATI_W), .SD_W(SD_W)) dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_done = 0, gcyc = 0, qend_g = 0;
  longint exp_q[$];
  string  tag_q[$];
  longint m_all[N], m_hp[N], m_cm[N], m_mc[N], m_ls[N];
  int modes[NQ] = '{1, 0, 2, 6, 3, 4, 5};
  string mtag[7] = '{"R2 R7", "R3 R5 R6", "R4 R5 R10", "R4 R7", "R8", "R5 R8", "R4 R6"};

  always @(posedge clk) gcyc <= gcyc + 1;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expect_sd(int i);
    longint mp, cl, em, q;
    if (m_all[i] == 0) return 256;
    mp = (m_mc[i] == 0) ? 1 : m_mc[i];
    cl = (m_mc[i] == 0) ? 0 : m_cm[i] * m_ls[i];
    em = E * mp;
    if (em <= cl) return 256;
    q = (m_hp[i] * Q * mp * 256) / (m_all[i] * (em - cl));
    if (q < 256) return 256;
    if (q > 65535) return 65535;
    return q;
  endfunction

  // Driver: one quantum of a stimulus pattern, with a scoreboard model.
  task automatic run_quantum(int mode);
    for (int i = 0; i < N; i++) begin
      m_all[i] = 0; m_hp[i] = 0; m_cm[i] = 0; m_mc[i] = 0; m_ls[i] = 0;
    end
    for (int c = 0; c < Q; c++) begin
      for (int i = 0; i < N; i++) begin
        logic own, a, m, h, f;
        int lat;
        own = ((c / E) == i);
        a = 0; m = 0; h = 0; f = 0; lat = 0;
        case (mode)
          1: a = own ? (c % 2 == 0) : ((c + i) % (i + 3) == 0);
          2, 3: begin
            a = own ? 1'b1 : (c % 4 == 0);
            m = own && (c % 8 == 0);
            h = m && ((mode == 3) || (c % 64 == 0));
            f = own && (c % 8 == 4);
            lat = 20 + 5 * i;
          end
          4: a = own ? (c % 4 == 0) : 1'b1;
          5: begin
            a = own;
            m = own && (c % E == 0); h = m;
            f = own && (c % E == 1);
            lat = (i % 2 == 0) ? 255 : 100;
          end
          6: begin
            a = own ? 1'b1 : (c % 2 == 0);
            m = own && (c % 4 == 0); h = m;
          end
          default: ;
        endcase
        acc_i[i] = a; miss_i[i] = m; aux_hit_i[i] = h; fill_i[i] = f;
        fill_lat_i[i*LATI_W +: LATI_W] = LATI_W'(lat);
        if (a) m_all[i]++;
        if (own && a) m_hp[i]++;
        if (own && m && h) m_cm[i]++;
        if (own && f) begin
          m_mc[i]++;
          m_ls[i] = (m_ls[i] + lat > LMAX) ? LMAX : m_ls[i] + lat;
        end
      end
      if (c % E == E / 2) check("R1 priority select", prio_o, longint'(1) << (c / E));
      @(negedge clk);
    end
    qend_g = gcyc;
    for (int i = 0; i < N; i++) begin
      exp_q.push_back(expect_sd(i));
      tag_q.push_back(mtag[mode]);
    end
  endtask

  // Monitor: pops expected slowdowns as each update completes.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && upd_done_o) begin
        check("R9 update latency", (gcyc - qend_g) <= LIMIT, 1);
        for (int i = 0; i < N; i++) begin
          if (exp_q.size() == 0) check("R9 unexpected update", 1, 0);
          else begin
            longint e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, slowdown_o[i*SD_W +: SD_W], e);
          end
        end
        n_done++;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset priority", prio_o, 1);
    check("R9 reset done flag", upd_done_o, 0);
    for (int i = 0; i < N; i++) check("R9 reset slowdown", slowdown_o[i*SD_W +: SD_W], 256);
    rst = 0;
    for (int k = 0; k < NQ; k++) run_quantum(modes[k]);
    acc_i = '0; miss_i = '0; aux_hit_i = '0; fill_i = '0;
    wait (n_done == NQ);
    @(negedge clk);
    check("R9 all updates consumed", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 60000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d updates", n_done, NQ);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule